// File: doc/BRIEF.md
# Crate-Bus Command Decoder with Overflow Interrupt

This block sits between a crate backplane and a 16K-word buffer memory. Every backplane command arrives as a function code, a subaddress and two strobe pulses, S1 and S2. Each strobe is abstracted to a single-cycle pulse. The block decodes the command and drives the read lines combinationally while the command is held. It moves or loads the memory pointer on the strobe that the command names. It returns the X (valid command) and Q (command executed) responses.

A two-bit ownership mode decides which port may touch the memory. The data and pointer commands execute only while the backplane owns it. The pointer has two guard bits above the memory address, so it can move past the top of the memory. The read lines then show that overflow, and Q is withheld for data transfers.

A reverse read walks the memory downward. It returns the pointer once, then returns words until address zero has been read. The block also keeps an interrupt request (LAM). The request is raised when the external overflow flag rises. It is tested, cleared, masked and unmasked by command, and it is cleared by the crate reset Z.

Top module: `cbus_fn_decoder`

## Requirements
- R1: Code 0 with subaddress 0 puts the word at the current pointer on the read lines. When the pointer is below 16384, Q=1 and the pointer increments at S2. Otherwise Q=0 and the pointer holds.
- R2: Code 1 with subaddress 0 puts the pointer, zero-extended, on the read lines. Code 1 with subaddress 1 puts the mode register on read lines [1:0] with Q=1.
- R3: Code 2 with subaddress 0 is a reverse read.
  - The first such command after any other command, or after Z, returns the pointer and leaves it unchanged.
  - Each later one returns the word at the pointer and decrements the pointer at S2.
  - Once the word at address 0 has been read, the pointer stays at 0 and Q=0 until another command is strobed.
- R4: Code 16 with subaddress 0 writes the write lines to the word at the pointer during S1 and increments the pointer at S1. When the pointer is not below 16384, there is no write and Q=0.
- R5: Code 17 loads at S1. With subaddress 0 the pointer is loaded from write lines [13:0], with the guard bits cleared. With subaddress 1 the mode register is loaded from write lines [1:0]. Mode value 01 means the backplane owns the memory.
- R6: The interrupt request is set on a rising edge of the overflow flag, and LAM equals request AND enable.
  - Code 8 returns Q equal to the request.
  - Code 10 returns Q equal to the request and clears the request at S2.
  - Code 24 clears the enable at S1, and code 26 sets it at S1.
  - All four of these codes use subaddress 0.
- R7: A cycle with Z high clears the pointer and the interrupt request. The next reverse read then returns the pointer.
- R8: X=1 exactly for the valid pairs: 0/0, 1/0, 1/1, 2/0, 8/0, 10/0, 16/0, 17/0, 17/1, 24/0 and 26/0. Q and the read lines are 0 whenever X=0.
- R9: While the mode is not 01, codes 0/0, 1/0, 2/0, 16/0 and 17/0 give Q=0 and change neither the pointer nor the memory. The mode commands 1/1 and 17/1 still execute.
- R10: After reset the pointer, the mode, the request and the enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_code | input | 5 | Function code of the held command |
| sub_a | input | 4 | Subaddress of the held command |
| wr_lines | input | 16 | Backplane write data |
| cmd_s1 | input | 1 | First strobe, one cycle |
| cmd_s2 | input | 1 | Second strobe, one cycle |
| z_reset | input | 1 | Crate reset Z |
| ovf_flag | input | 1 | Overflow level from the threshold comparator |
| mem_rdata | input | 16 | Word read from the memory at mem_addr |
| rd_lines | output | 16 | Backplane read data |
| x_resp | output | 1 | Valid command response |
| q_resp | output | 1 | Executed command response |
| lam_out | output | 1 | Interrupt request to the crate |
| mem_addr | output | 14 | Memory address, the low bits of the pointer |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| own_mode | output | 2 | Current ownership mode for the other ports |

## Verification
A wrong pointer shows up at the next pointer read or data read. It appears on the read lines in the same cycle the command is presented. A stuck reverse-read flag shows up as a wrong first reverse-read value or as a Q that is wrongly withheld. A bad interrupt request or enable shows on LAM one clock after the strobe or overflow edge that should have changed it. It also shows in the Q of the test command.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

   localparam int unsigned FN_W  = 5;
   localparam int unsigned SUB_W = 4;

   localparam logic [FN_W-1:0] FN_RD_UP   = 5'd0;
   localparam logic [FN_W-1:0] FN_RD_REG  = 5'd1;
   localparam logic [FN_W-1:0] FN_RD_DOWN = 5'd2;
   localparam logic [FN_W-1:0] FN_TST     = 5'd8;
   localparam logic [FN_W-1:0] FN_TST_CLR = 5'd10;
   localparam logic [FN_W-1:0] FN_WR_UP   = 5'd16;
   localparam logic [FN_W-1:0] FN_WR_REG  = 5'd17;
   localparam logic [FN_W-1:0] FN_MASK    = 5'd24;
   localparam logic [FN_W-1:0] FN_UNMASK  = 5'd26;

   typedef struct packed {
      logic valid;
      logic need_own;
      logic rd_up;
      logic rd_ptr;
      logic rd_mode;
      logic rd_down;
      logic wr_up;
      logic ld_ptr;
      logic ld_mode;
      logic irq_test;
      logic irq_clear;
      logic irq_mask;
      logic irq_unmask;
   } cmd_dec_t;

endpackage

// File: rtl/cbus_cmd_decode.sv
module cbus_cmd_decode
   import cbus_pkg::*;
(
   input  logic [FN_W-1:0]  f_code,
   input  logic [SUB_W-1:0] sub_a,
   output cmd_dec_t         dec
);

   logic a0;
   logic a1;

   assign a0 = (sub_a == SUB_W'(0));
   assign a1 = (sub_a == SUB_W'(1));

   always_comb begin
      dec = '0;
      unique case (f_code)
         FN_RD_UP: begin
            dec.rd_up    = a0;
            dec.need_own = 1'b1;
         end
         FN_RD_REG: begin
            dec.rd_ptr   = a0;
            dec.rd_mode  = a1;
            dec.need_own = a0;
         end
         FN_RD_DOWN: begin
            dec.rd_down  = a0;
            dec.need_own = 1'b1;
         end
         FN_TST:     dec.irq_test   = a0;
         FN_TST_CLR: dec.irq_clear  = a0;
         FN_WR_UP: begin
            dec.wr_up    = a0;
            dec.need_own = 1'b1;
         end
         FN_WR_REG: begin
            dec.ld_ptr   = a0;
            dec.ld_mode  = a1;
            dec.need_own = a0;
         end
         FN_MASK:    dec.irq_mask   = a0;
         FN_UNMASK:  dec.irq_unmask = a0;
         default: ;
      endcase
      dec.valid = dec.rd_up | dec.rd_ptr | dec.rd_mode | dec.rd_down |
                  dec.wr_up | dec.ld_ptr | dec.ld_mode | dec.irq_test |
                  dec.irq_clear | dec.irq_mask | dec.irq_unmask;
   end

endmodule

// File: rtl/cbus_ptr_ctl.sv
module cbus_ptr_ctl #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned PTR_W  = ADDR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              z_clr,
   input  logic              step_up,
   input  logic              step_down,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              other_cmd,
   output logic [PTR_W-1:0]  ptr_q,
   output logic              first_q,
   output logic              done_q
);

   logic at_zero;
   assign at_zero = (ptr_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         first_q <= 1'b1;
         done_q  <= 1'b0;
      end else if (z_clr) begin
         ptr_q   <= '0;
         first_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         if (load_en) begin
            ptr_q <= PTR_W'(load_val);
         end else if (step_up) begin
            ptr_q <= ptr_q + PTR_W'(1);
         end else if (step_down && !first_q && !at_zero) begin
            ptr_q <= ptr_q - PTR_W'(1);
         end
         if (step_down) begin
            if (first_q) begin
               first_q <= 1'b0;
            end else if (at_zero) begin
               done_q <= 1'b1;
            end
         end else if (other_cmd) begin
            first_q <= 1'b1;
            done_q  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cbus_irq_ctl.sv
module cbus_irq_ctl #(
   parameter bit EDGE_SET = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic z_clr,
   input  logic ovf,
   input  logic clr_req,
   input  logic mask,
   input  logic unmask,
   output logic req_q,
   output logic en_q,
   output logic irq
);

   logic set_req;

   generate
      if (EDGE_SET) begin : g_edge
         logic ovf_d;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ovf_d <= 1'b0;
            else        ovf_d <= ovf;
         end
         assign set_req = ovf & ~ovf_d;
      end else begin : g_level
         assign set_req = ovf;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         en_q  <= 1'b0;
      end else begin
         if (z_clr || clr_req) req_q <= 1'b0;
         else if (set_req)     req_q <= 1'b1;
         if (mask)             en_q <= 1'b0;
         else if (unmask)      en_q <= 1'b1;
      end
   end

   assign irq = req_q & en_q;

endmodule

// File: rtl/cbus_fn_decoder.sv
module cbus_fn_decoder
   import cbus_pkg::*;
#(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned MODE_W   = 2,
   parameter logic [1:0]  OWN_CODE = 2'b01,
   parameter bit          EDGE_SET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FN_W-1:0]   f_code,
   input  logic [SUB_W-1:0]  sub_a,
   input  logic [DATA_W-1:0] wr_lines,
   input  logic              cmd_s1,
   input  logic              cmd_s2,
   input  logic              z_reset,
   input  logic              ovf_flag,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rd_lines,
   output logic              x_resp,
   output logic              q_resp,
   output logic              lam_out,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [MODE_W-1:0] own_mode
);

   localparam int unsigned PTR_W = ADDR_W + 2;
   localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;

   generate
      if (DATA_W < PTR_W) begin : g_bad_data_w
         $error("DATA_W must hold the pointer with its guard bits");
      end
      if (MODE_W != 2) begin : g_bad_mode_w
         $error("MODE_W must be 2");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W too small");
      end
   endgenerate

   cmd_dec_t          dec;
   logic [MODE_W-1:0] mode_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              first_q;
   logic              done_q;
   logic              req_q;
   logic              en_q;
   logic              owned;
   logic              in_range;
   logic              exec;
   logic              q_int;
   logic [DATA_W-1:0] rd_sel;

   cbus_cmd_decode u_dec (
      .f_code (f_code),
      .sub_a  (sub_a),
      .dec    (dec)
   );

   assign owned    = (mode_q == MODE_W'(OWN_CODE));
   assign in_range = (ptr_q < DEPTH);
   assign exec     = dec.valid & (~dec.need_own | owned);

   always_comb begin
      q_int = exec;
      if (dec.rd_up || dec.wr_up)          q_int = exec & in_range;
      if (dec.rd_down)                     q_int = exec & ~done_q;
      if (dec.irq_test || dec.irq_clear)   q_int = exec & req_q;
   end

   always_comb begin
      rd_sel = '0;
      if (dec.rd_up)   rd_sel = mem_rdata;
      if (dec.rd_ptr)  rd_sel = DATA_W'(ptr_q);
      if (dec.rd_mode) rd_sel = DATA_W'(mode_q);
      if (dec.rd_down) rd_sel = first_q ? DATA_W'(ptr_q) : mem_rdata;
   end

   assign rd_lines = q_int ? rd_sel : '0;
   assign x_resp   = dec.valid;
   assign q_resp   = q_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mode_q <= '0;
      else if (exec && dec.ld_mode && cmd_s1) mode_q <= wr_lines[MODE_W-1:0];
   end

   cbus_ptr_ctl #(
      .ADDR_W (ADDR_W),
      .PTR_W  (PTR_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .z_clr     (z_reset),
      .step_up   (q_int & ((dec.rd_up & cmd_s2) | (dec.wr_up & cmd_s1))),
      .step_down (q_int & dec.rd_down & cmd_s2),
      .load_en   (exec & dec.ld_ptr & cmd_s1),
      .load_val  (wr_lines[ADDR_W-1:0]),
      .other_cmd (cmd_s2 & ~dec.rd_down),
      .ptr_q     (ptr_q),
      .first_q   (first_q),
      .done_q    (done_q)
   );

   cbus_irq_ctl #(
      .EDGE_SET (EDGE_SET)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .z_clr   (z_reset),
      .ovf     (ovf_flag),
      .clr_req (exec & dec.irq_clear & cmd_s2),
      .mask    (exec & dec.irq_mask & cmd_s1),
      .unmask  (exec & dec.irq_unmask & cmd_s1),
      .req_q   (req_q),
      .en_q    (en_q),
      .irq     (lam_out)
   );

   assign mem_addr  = ptr_q[ADDR_W-1:0];
   assign mem_we    = exec & dec.wr_up & in_range & cmd_s1;
   assign mem_wdata = wr_lines;
   assign own_mode  = mode_q;

endmodule

// File: rtl/cbus_fn_decoder_chk.sv
module cbus_fn_decoder_chk #(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned PTR_W    = ADDR_W + 2,
   parameter logic [1:0]  OWN_CODE = 2'b01
) (
   input logic             clk,
   input logic             rst_n,
   input logic [4:0]       f_code,
   input logic [3:0]       sub_a,
   input logic             cmd_s1,
   input logic             cmd_s2,
   input logic             z_reset,
   input logic             x_resp,
   input logic             q_resp,
   input logic             lam_out,
   input logic             mem_we,
   input logic [1:0]       mode_q,
   input logic [PTR_W-1:0] ptr_q,
   input logic             done_q,
   input logic             en_q
);

   logic owned;
   logic below_top;
   assign owned     = (mode_q == OWN_CODE);
   assign below_top = (ptr_q < (PTR_W'(1) << ADDR_W));

   // R1: forward read steps the pointer by one at S2
   a_r1_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (f_code == 5'd0 && sub_a == 4'd0 && owned && below_top && cmd_s2 && !z_reset)
      |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

   // R3: no Q once address 0 has been read backwards
   a_r3_down_done: assert property (@(posedge clk) disable iff (!rst_n)
      (f_code == 5'd2 && sub_a == 4'd0 && done_q) |-> !q_resp);

   // R4: writes only on an owned write command during S1
   a_r4_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (cmd_s1 && f_code == 5'd16 && sub_a == 4'd0 && owned && below_top));

   // R6: the interrupt reaches the crate only while enabled
   a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
      lam_out |-> en_q);

   // R7: Z clears pointer and interrupt
   a_r7_z_clears: assert property (@(posedge clk) disable iff (!rst_n)
      z_reset |=> (ptr_q == '0 && !lam_out));

   // R8: no Q without X
   a_r8_q_needs_x: assert property (@(posedge clk) disable iff (!rst_n)
      !x_resp |-> !q_resp);

   // R9: memory commands silent without ownership
   a_r9_not_owned: assert property (@(posedge clk) disable iff (!rst_n)
      (!owned && sub_a == 4'd0 &&
       (f_code == 5'd0 || f_code == 5'd1 || f_code == 5'd2 ||
        f_code == 5'd16 || f_code == 5'd17)) |-> !q_resp);

endmodule

bind cbus_fn_decoder cbus_fn_decoder_chk #(
   .ADDR_W   (ADDR_W),
   .PTR_W    (ADDR_W + 2),
   .OWN_CODE (OWN_CODE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .f_code  (f_code),
   .sub_a   (sub_a),
   .cmd_s1  (cmd_s1),
   .cmd_s2  (cmd_s2),
   .z_reset (z_reset),
   .x_resp  (x_resp),
   .q_resp  (q_resp),
   .lam_out (lam_out),
   .mem_we  (mem_we),
   .mode_q  (mode_q),
   .ptr_q   (ptr_q),
   .done_q  (done_q),
   .en_q    (en_q)
);

// File: tb/cbus_fn_decoder_tb.sv
module cbus_fn_decoder_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  f_code = '0;
   logic [3:0]  sub_a = '0;
   logic [15:0] wr_lines = '0;
   logic        cmd_s1 = 1'b0;
   logic        cmd_s2 = 1'b0;
   logic        z_reset = 1'b0;
   logic        ovf_flag = 1'b0;
   logic [15:0] mem_rdata;
   logic [15:0] rd_lines;
   logic        x_resp, q_resp, lam_out, mem_we;
   logic [13:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [1:0]  own_mode;

   logic [15:0] tb_mem [0:63];
   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   cbus_fn_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .f_code(f_code), .sub_a(sub_a),
      .wr_lines(wr_lines), .cmd_s1(cmd_s1), .cmd_s2(cmd_s2),
      .z_reset(z_reset), .ovf_flag(ovf_flag), .mem_rdata(mem_rdata),
      .rd_lines(rd_lines), .x_resp(x_resp), .q_resp(q_resp),
      .lam_out(lam_out), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .own_mode(own_mode)
   );

   assign mem_rdata = tb_mem[mem_addr[5:0]];
   always @(posedge clk) if (mem_we) tb_mem[mem_addr[5:0]] <= mem_wdata;

   // {f, a, w, x, q, rd, check_rd}
   localparam int NV = 18;
   localparam logic [43:0] VEC [0:NV-1] = '{
      {5'd17, 4'd1, 16'h0001, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd1,  4'd1, 16'h0000, 1'b1, 1'b1, 16'h0001, 1'b1},
      {5'd17, 4'd0, 16'h0005, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd1,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h0005, 1'b1},
      {5'd16, 4'd0, 16'hAAAA, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd16, 4'd0, 16'h5555, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd1,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h0007, 1'b1},
      {5'd17, 4'd0, 16'h0005, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd0,  4'd0, 16'h0000, 1'b1, 1'b1, 16'hAAAA, 1'b1},
      {5'd0,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h5555, 1'b1},
      {5'd17, 4'd0, 16'h0006, 1'b1, 1'b1, 16'h0000, 1'b0},
      {5'd2,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h0006, 1'b1},
      {5'd2,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h5555, 1'b1},
      {5'd2,  4'd0, 16'h0000, 1'b1, 1'b1, 16'hAAAA, 1'b1},
      {5'd1,  4'd0, 16'h0000, 1'b1, 1'b1, 16'h0004, 1'b1},
      {5'd5,  4'd0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      {5'd1,  4'd2, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1},
      {5'd8,  4'd0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [4:0] f, input logic [3:0] a, input logic [15:0] w,
                      output logic xo, output logic qo, output logic [15:0] ro);
      @(negedge clk);
      f_code = f; sub_a = a; wr_lines = w;
      #1;
      xo = x_resp; qo = q_resp; ro = rd_lines;
      cmd_s1 = 1'b1;
      @(negedge clk);
      cmd_s1 = 1'b0; cmd_s2 = 1'b1;
      @(negedge clk);
      cmd_s2 = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic xo, qo;
      logic [15:0] ro;
      for (int i = 0; i < 64; i++) tb_mem[i] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state
      check(lam_out == 1'b0, "R10 lam", lam_out, 0);
      check(own_mode == 2'b00, "R10 mode", own_mode, 0);
      cmd(5'd1, 4'd1, 16'h0, xo, qo, ro);
      check(qo && ro == 16'h0, "R10 mode read", ro, 0);

      // vector table: R1 R2 R3 R4 R5 R8
      for (int i = 0; i < NV; i++) begin
         cmd(VEC[i][43:39], VEC[i][38:35], VEC[i][34:19], xo, qo, ro);
         check(xo == VEC[i][18] && qo == VEC[i][17], $sformatf("R8 vec%0d x/q", i),
               {xo, qo}, {VEC[i][18], VEC[i][17]});
         if (VEC[i][0])
            check(ro == VEC[i][16:1], $sformatf("R1 R2 R3 vec%0d rd", i), ro, VEC[i][16:1]);
      end

      // R9: ownership gating (pointer is 4)
      cmd(5'd17, 4'd1, 16'h0002, xo, qo, ro);
      cmd(5'd16, 4'd0, 16'h1234, xo, qo, ro);
      check(!qo, "R9 write q", qo, 0);
      cmd(5'd1, 4'd0, 16'h0, xo, qo, ro);
      check(!qo && ro == 0, "R9 ptr read q", qo, 0);
      cmd(5'd17, 4'd1, 16'h0001, xo, qo, ro);
      cmd(5'd1, 4'd0, 16'h0, xo, qo, ro);
      check(ro == 16'h0004, "R9 ptr kept", ro, 4);
      cmd(5'd0, 4'd0, 16'h0, xo, qo, ro);
      check(ro == 16'h0000, "R9 mem kept", ro, 0);

      // R1 R4: range limit
      cmd(5'd17, 4'd0, 16'h3FFF, xo, qo, ro);
      cmd(5'd16, 4'd0, 16'h0BEE, xo, qo, ro);
      check(qo, "R4 last word q", qo, 1);
      cmd(5'd1, 4'd0, 16'h0, xo, qo, ro);
      check(ro == 16'h4000, "R4 ptr past top", ro, 16'h4000);
      cmd(5'd0, 4'd0, 16'h0, xo, qo, ro);
      check(!qo, "R1 out of range q", qo, 0);
      cmd(5'd16, 4'd0, 16'h0, xo, qo, ro);
      check(!qo, "R4 out of range q", qo, 0);
      cmd(5'd1, 4'd0, 16'h0, xo, qo, ro);
      check(ro == 16'h4000, "R1 ptr held", ro, 16'h4000);

      // R3: reverse read down to zero
      cmd(5'd17, 4'd0, 16'h0001, xo, qo, ro);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(qo && ro == 16'h0001, "R3 first", ro, 1);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(qo, "R3 word1 q", qo, 1);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(qo, "R3 word0 q", qo, 1);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(!qo, "R3 past zero q", qo, 0);
      cmd(5'd1, 4'd0, 16'h0, xo, qo, ro);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(qo && ro == 16'h0000, "R3 rearmed", ro, 0);

      // R6: interrupt
      cmd(5'd26, 4'd0, 16'h0, xo, qo, ro);
      @(negedge clk); ovf_flag = 1'b1;
      @(negedge clk);
      check(lam_out, "R6 raised", lam_out, 1);
      cmd(5'd8, 4'd0, 16'h0, xo, qo, ro);
      check(qo, "R6 test q", qo, 1);
      cmd(5'd24, 4'd0, 16'h0, xo, qo, ro);
      check(!lam_out, "R6 masked", lam_out, 0);
      cmd(5'd26, 4'd0, 16'h0, xo, qo, ro);
      check(lam_out, "R6 unmasked", lam_out, 1);
      cmd(5'd10, 4'd0, 16'h0, xo, qo, ro);
      check(qo && !lam_out, "R6 test clear", lam_out, 0);

      // R7: Z
      @(negedge clk); ovf_flag = 1'b0;
      @(negedge clk); ovf_flag = 1'b1;
      @(negedge clk);
      check(lam_out, "R7 pre lam", lam_out, 1);
      cmd(5'd17, 4'd0, 16'h0009, xo, qo, ro);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      @(negedge clk); z_reset = 1'b1;
      @(negedge clk); z_reset = 1'b0;
      check(!lam_out, "R7 lam cleared", lam_out, 0);
      cmd(5'd2, 4'd0, 16'h0, xo, qo, ro);
      check(qo && ro == 16'h0000, "R7 ptr zero first", ro, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule